// File: doc/BRIEF.md
# Gated Frame-Buffer Scan-Out Engine

This block turns a linear frame buffer into a stream of pixels. An external sync generator supplies two gates. The frame gate is high for the visible part of a frame, and the line gate is high for the visible dots of each line. The engine owns one address counter into video RAM. The counter is cleared whenever the frame gate is low. While both gates are high, the engine steps the counter forward one byte at a time through consecutive addresses. It keeps no internal X or Y position and applies no per-line stride, so one line's data follows straight on from the previous line's data.

In each fetch slot the engine samples the RAM read data and loads that byte into a shift register. The shift register then sends the byte out, most significant bits first, over the following dots. In monochrome mode a byte holds eight one-bit pixels, so a fetch happens once every eight dots. In four-colour mode a byte holds four two-bit pixels, so a fetch happens once every four dots. The engine raises `fetch_slot` only during the dot it reserves for its own read. Any other RAM user, such as a host write path, may use the RAM in every dot where `fetch_slot` is low. In monochrome mode that leaves seven free dots out of every eight.

Top module: `fb_scanout`

## Requirements
- R1: In the cycle after any cycle in which `frame_gate` is low, `ram_addr` is 0. While `frame_gate` stays low, `ram_addr` stays 0 and `fetch_slot` stays 0, whatever `line_gate` does.
- R2: While `frame_gate` is high, `ram_addr` rises by exactly one at each clock edge that ends a cycle with `fetch_slot` high. At every other edge it holds its value.
- R3: Counting the dots of a line-gate-high run from 0, `fetch_slot` is high at dot 0 and then on every 8th dot in monochrome mode (`four_colour`=0) or every 4th dot in four-colour mode (`four_colour`=1). It is low in every other dot, and low whenever `line_gate` is low.
- R4: The byte loaded is the value on `ram_rdata` at the clock edge that ends the fetch slot. That value belongs to the address shown on `ram_addr` during the slot.
- R5: Monochrome mode: in the dots after a fetch, `pix[0]` presents the byte's bits in the order 7, 6, … , 0, one bit per dot, and `pix[1]` is 0. The first bit appears in the dot right after the fetch slot.
- R6: Four-colour mode: in the dots after a fetch, `pix[1:0]` presents bits [7:6], then [5:4], then [3:2], then [1:0], one pair per dot. The first pair appears in the dot right after the fetch slot.
- R7: `pix` is 0 in every dot that follows a dot in which `line_gate` or `frame_gate` was low.
- R8: A line whose length is not a multiple of the fetch period ends with a partly shown byte. The next line starts at the address that follows the last fetched byte, with no address gap and no wraparound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_gate | input | 1 | High during the visible lines of a frame; low clears the address |
| line_gate | input | 1 | High during the visible dots of a line |
| four_colour | input | 1 | 0 selects monochrome (1 bit/pixel), 1 selects four-colour (2 bits/pixel); changed only while frame_gate is low |
| ram_rdata | input | 8 | Read data returned by video RAM for `ram_addr` |
| ram_addr | output | ADDR_W | Video RAM read address |
| fetch_slot | output | 1 | High in the dot reserved for the display read |
| pix | output | 2 | Pixel value; in monochrome mode only bit 0 is used |

## Verification
The bench drives whole frames in both modes, using lines whose lengths are whole multiples of the fetch period, lines with a partial last byte, and a single-dot line. The whole-length lines show the basic fetch cadence and the bit order. The partial lines show that the address counts on across lines without a stride. The RAM model returns a different value, computed from the address, for every byte. A pixel taken from the wrong address or shown in the wrong bit order therefore breaks the expected stream at once. Line-gate activity while the frame gate is low separates a true clear of the address from an address that merely goes idle.

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_gate,
  input  logic              line_gate,
  input  logic              four_colour,
  input  logic [7:0]        ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              fetch_slot,
  output logic [1:0]        pix
);

  logic [2:0] phase;
  logic [7:0] shreg;
  logic       show;
  logic       active;

  assign active     = line_gate & frame_gate;
  assign fetch_slot = active & (four_colour ? (phase[1:0] == 2'd0) : (phase == 3'd0));
  assign pix        = !show ? 2'b00 : (four_colour ? shreg[7:6] : {1'b0, shreg[7]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      shreg    <= '0;
      show     <= 1'b0;
      ram_addr <= '0;
    end else begin
      show  <= active;
      phase <= active ? phase + 3'd1 : 3'd0;
      if (!frame_gate)
        ram_addr <= '0;
      else if (fetch_slot)
        ram_addr <= ram_addr + 1'b1;
      if (fetch_slot)
        shreg <= ram_rdata;
      else if (four_colour)
        shreg <= {shreg[5:0], 2'b00};
      else
        shreg <= {shreg[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/fb_scanout_checker.sv
module fb_scanout_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_gate,
  input logic              line_gate,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              fetch_slot,
  input logic [1:0]        pix
);

  AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_gate |=> ram_addr == '0); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_gate && fetch_slot) |=> ram_addr == $past(ram_addr) + 1'b1); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_gate && !fetch_slot) |=> ram_addr == $past(ram_addr)); // R2

  AST_SLOT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_gate && frame_gate) |-> !fetch_slot); // R3

  AST_SLOT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_slot |=> !fetch_slot); // R3

  AST_PIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_gate && frame_gate) |=> pix == 2'b00); // R7

endmodule

bind fb_scanout fb_scanout_checker #(.ADDR_W(ADDR_W)) u_fb_scanout_checker (
  .clk(clk), .rst_n(rst_n), .frame_gate(frame_gate), .line_gate(line_gate),
  .ram_addr(ram_addr), .fetch_slot(fetch_slot), .pix(pix)
);

// File: tb/fb_scanout_bench.sv
module fb_scanout_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_gate = 1'b0;
  logic          line_gate = 1'b0;
  logic          four_colour = 1'b0;
  logic [7:0]    ram_rdata;
  logic [AW-1:0] ram_addr;
  logic          fetch_slot;
  logic [1:0]    pix;

  int checks = 0;
  int errors = 0;
  int base   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem(input int a);
    return 8'((a * 29 + 91) & 255);
  endfunction

  assign ram_rdata = mem(int'(ram_addr));

  fb_scanout #(.ADDR_W(AW)) u_fb_scanout (
    .clk(clk), .rst_n(rst_n), .frame_gate(frame_gate), .line_gate(line_gate),
    .four_colour(four_colour), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
    .fetch_slot(fetch_slot), .pix(pix)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_line(input int len);
    int p;
    p = four_colour ? 4 : 8;
    for (int k = 0; k < len + 3; k++) begin
      int kc;
      int ea;
      int ep;
      line_gate = (k < len);
      @(negedge clk);
      kc = (k < len) ? k : len;
      ea = base + (kc + p - 1) / p;
      check("R2", int'(ram_addr), ea);
      check("R3", int'(fetch_slot), int'((k < len) && (k % p == 0)));
      if (k >= 1 && k <= len) begin
        logic [7:0] b;
        int j;
        b = mem(base + (k - 1) / p);
        j = (k - 1) % p;
        if (four_colour) ep = int'((b >> (6 - 2 * j)) & 8'd3);
        else             ep = int'(b[7 - j]);
        check(four_colour ? "R6" : "R5", int'(pix), ep);
      end else begin
        check("R7", int'(pix), 0);
      end
      @(posedge clk); #1;
    end
    base = base + (len + p - 1) / p;
  endtask

  task automatic end_frame();
    frame_gate = 1'b0;
    line_gate  = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    check("R1", int'(ram_addr), 0);
    line_gate = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R1", int'(ram_addr), 0);
      check("R1", int'(fetch_slot), 0);
      if (i > 0) check("R7", int'(pix), 0);
      @(posedge clk); #1;
    end
    line_gate = 1'b0;
    base = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1", int'(ram_addr), 0);
    check("R3", int'(fetch_slot), 0);
    check("R7", int'(pix), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // Monochrome frame: whole lines (R4, R5), partial lines (R8)
    four_colour = 1'b0;
    frame_gate  = 1'b1;
    run_line(24);
    run_line(24);
    run_line(11);
    run_line(16);
    run_line(1);
    run_line(8);
    end_frame();

    // Four-colour frame (R6, R8)
    four_colour = 1'b1;
    frame_gate  = 1'b1;
    run_line(8);
    run_line(13);
    run_line(4);
    run_line(2);
    run_line(12);
    end_frame();

    // Monochrome again after clear: restarts from address 0 (R1, R2)
    four_colour = 1'b0;
    frame_gate  = 1'b1;
    run_line(40);
    run_line(5);
    end_frame();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule